// File: doc/BRIEF.md
# PCI Configuration Cycle Address Decoder

This block sits at the front of a host bridge. It watches CPU bus requests and turns the ones aimed at configuration space into requests on a downstream configuration port. Two paths lead there. A 4 MiB memory window based at 0x8080_0000 maps an address straight onto a configuration address. In that address, a one-hot select field is collapsed into a binary device number by a priority encoder. A legacy pair of I/O registers, an index at 0xCF8 and a data port at 0xCFC, forwards accesses through a stored configuration address.

The block also serves one byte at 0xBFFF_FFF0. A read there fetches an interrupt vector from an external interrupt controller over a request/valid handshake. Separately, the block folds the four interrupt pins of each device slot onto the bus interrupt outputs with a parity swizzle.

Only one request is in flight at a time. Reads, and writes that go downstream, hold the CPU response until the downstream side answers. Accesses outside every decoded region are not claimed, so some other target can answer them.

Top module: `cfg_cycle_decoder`

## Requirements
- R1: A memory access (reqIo=0) whose address lies in [0x8080_0000, 0x80C0_0000) raises claim in its accept cycle and issues one downstream request. Addresses just below or above the window, and I/O accesses to the same addresses, are not claimed.
- R2: For a window access, cfgReqAddr[10:0] equals address bits [10:0] and cfgReqAddr[23:16] is zero.
- R3: For a window access, cfgReqAddr[15:11] is the index (0..10) of the lowest set bit among address bits 21..11; if none of them is set it is 11. Higher set bits do not change the result.
- R4: The size code is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes, and 3 is invalid. cfgReqBe has bit k set for each byte at offset k covered by the access. A 2-byte access with address bit 0 set, a 4-byte access with address bits [1:0] nonzero, or size code 3 gets a response with rspError=1 and rspRdata=0, and nothing goes downstream.
- R5: Window data is little-endian: the byte at offset k sits on bits [8k+7:8k]. cfgReqWdata equals reqWdata, and rspRdata equals cfgRspData.
- R6: The index register is at I/O address 0xCF8 and accepts only aligned 4-byte accesses; any other size is an error and leaves it unchanged. The register is big-endian: it stores reqWdata byte-reversed, and a read returns it byte-reversed, so a read returns exactly what was written.
- R7: The data port covers I/O addresses 0xCFC..0xCFF and uses the R4 size rules. When index bit 31 is set, the access goes downstream with cfgReqAddr = {index[23:2], address[1:0]}, byte-reversed write data and byte-reversed read data. When bit 31 is clear, nothing goes downstream: a read returns 0xFFFF_FFFF and a write completes without error.
- R8: A 1-byte memory read at exactly 0xBFFF_FFF0 pulses iackReq and returns {24'b0, iackVector} once iackValid is seen. A wider read there is an error with no iackReq. A write there completes without error and without iackReq.
- R9: A downstream access raises cfgReqValid for exactly one cycle. reqReady stays low until cfgRspValid arrives, and rspValid follows one cycle later.
- R10: An access that hits no decoded region gets no claim, no response and no downstream or acknowledge request.
- R11: irqOut[k] is the OR of every slot s pin p (intPins[4s+p]) with (p+s) mod 2 = k. irqOut[3:2] are always 0.
- R12: After reset, reqReady=1, rspValid, cfgReqValid and iackReq are 0, and the index register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | CPU request present |
| reqIo | input | 1 | 1 = I/O space, 0 = memory space |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | CPU byte address |
| reqSize | input | 2 | Size code: 0 = 1 B, 1 = 2 B, 2 = 4 B |
| reqWdata | input | 32 | CPU write data |
| reqReady | output | 1 | Block can accept a request |
| claim | output | 1 | Request accepted by a decoded region |
| rspValid | output | 1 | One-cycle CPU response |
| rspError | output | 1 | Response carries an error |
| rspRdata | output | 32 | Response read data |
| cfgReqValid | output | 1 | One-cycle downstream request |
| cfgReqWrite | output | 1 | Downstream request is a write |
| cfgReqAddr | output | 24 | Bus, device, function and register address |
| cfgReqBe | output | 4 | Downstream byte enables |
| cfgReqWdata | output | 32 | Downstream write data, little-endian |
| cfgRspValid | input | 1 | Downstream completion |
| cfgRspData | input | 32 | Downstream read data |
| iackReq | output | 1 | One-cycle vector request to interrupt controller |
| iackValid | input | 1 | Vector available |
| iackVector | input | 8 | Interrupt vector |
| intPins | input | 16 | Four pins for each of four device slots |
| irqOut | output | 4 | Swizzled bus interrupt outputs |

## Verification
The window is driven with every single-bit device select, with multiple select bits set at once, and with no select bit at all. These cases separate a correct lowest-bit priority encoder from one that scans in the wrong direction or gets the no-bit default wrong. All sixteen pairs of size code and low address bits are tried, which tells correct byte-enable shifting apart from faulty alignment rejection. Legacy accesses are made with the enable bit both set and clear and use asymmetric byte patterns, so a missing or doubled byte swap shows up. The swizzle is checked against every one of the 65,536 pin combinations.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

  typedef enum logic [2:0] {
    RG_MISS,
    RG_DIRECT,
    RG_INDEX,
    RG_DATA,
    RG_IACK
  } region_e;

  typedef struct packed {
    region_e region;
    logic    sizeOk;
    logic    legacyOn;
  } decode_t;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_CFG,
    RD_IACK,
    RD_INDEX,
    RD_ONES
  } rdsel_e;

  typedef struct packed {
    logic   issueCfg;
    logic   writeIndex;
    logic   loadRsp;
    rdsel_e rdSel;
  } strobe_t;

  function automatic logic [31:0] swapBytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/cfgdec_datapath.sv
module cfgdec_datapath
  import cfgdec_pkg::*;
#(
  parameter logic [31:0] CFG_BASE      = 32'h8080_0000,
  parameter int          WIN_LOG2      = 22,
  parameter int          SEL_LSB       = 11,
  parameter int          SEL_BITS      = 11,
  parameter logic [31:0] IDX_ADDR      = 32'h0000_0CF8,
  parameter logic [31:0] DATA_ADDR     = 32'h0000_0CFC,
  parameter logic [31:0] IACK_ADDR     = 32'hBFFF_FFF0,
  parameter int          CFG_ADDR_W    = 24,
  parameter int          NUM_SLOTS     = 4,
  parameter int          PINS_PER_SLOT = 4,
  parameter int          NUM_IRQ       = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               reqIo,
  input  logic                               reqWrite,
  input  logic [31:0]                        reqAddr,
  input  logic [1:0]                         reqSize,
  input  logic [31:0]                        reqWdata,
  output decode_t                            decode,
  input  strobe_t                            strobe,
  input  logic [31:0]                        cfgRspData,
  input  logic [7:0]                         iackVector,
  output logic [CFG_ADDR_W-1:0]              cfgReqAddr,
  output logic [3:0]                         cfgReqBe,
  output logic [31:0]                        cfgReqWdata,
  output logic [31:0]                        rspRdata,
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] intPins,
  output logic [NUM_IRQ-1:0]                 irqOut
);

  localparam int DEV_W = $clog2(SEL_BITS + 1);

  logic [DEV_W-1:0]      devNum;
  logic [3:0]            laneBe;
  logic                  laneOk;
  region_e               region;
  logic [31:0]           indexReg;
  logic                  swapHeld;
  logic [CFG_ADDR_W-1:0] directAddr;
  logic [CFG_ADDR_W-1:0] legacyAddr;

  // lowest set select bit wins; none set selects SEL_BITS
  always_comb begin
    devNum = DEV_W'(SEL_BITS);
    for (int i = SEL_BITS - 1; i >= 0; i--) begin
      if (reqAddr[SEL_LSB + i]) devNum = DEV_W'(i);
    end
  end

  always_comb begin
    laneBe = 4'b0000;
    laneOk = 1'b0;
    case (reqSize)
      2'd0: begin laneBe = 4'b0001 << reqAddr[1:0]; laneOk = 1'b1; end
      2'd1: begin laneBe = 4'b0011 << reqAddr[1:0]; laneOk = !reqAddr[0]; end
      2'd2: begin laneBe = 4'b1111; laneOk = (reqAddr[1:0] == 2'b00); end
      default: ;
    endcase
  end

  always_comb begin
    region = RG_MISS;
    if (!reqIo && reqAddr[31:WIN_LOG2] == CFG_BASE[31:WIN_LOG2]) region = RG_DIRECT;
    else if (!reqIo && reqAddr == IACK_ADDR)                     region = RG_IACK;
    else if (reqIo && reqAddr[31:2] == IDX_ADDR[31:2])           region = RG_INDEX;
    else if (reqIo && reqAddr[31:2] == DATA_ADDR[31:2])          region = RG_DATA;
  end

  always_comb begin
    decode.region   = region;
    decode.legacyOn = indexReg[31];
    case (region)
      RG_INDEX: decode.sizeOk = laneOk && (reqSize == 2'd2);
      RG_IACK:  decode.sizeOk = reqWrite || (reqSize == 2'd0);
      default:  decode.sizeOk = laneOk;
    endcase
  end

  assign directAddr = (CFG_ADDR_W'(devNum) << SEL_LSB)
                    | CFG_ADDR_W'(reqAddr[SEL_LSB-1:0]);
  assign legacyAddr = {indexReg[CFG_ADDR_W-1:2], reqAddr[1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReqAddr  <= '0;
      cfgReqBe    <= '0;
      cfgReqWdata <= '0;
      swapHeld    <= 1'b0;
      indexReg    <= '0;
      rspRdata    <= '0;
    end else begin
      if (strobe.issueCfg) begin
        swapHeld    <= (region == RG_DATA);
        cfgReqAddr  <= (region == RG_DATA) ? legacyAddr : directAddr;
        cfgReqBe    <= laneBe;
        cfgReqWdata <= (region == RG_DATA) ? swapBytes(reqWdata) : reqWdata;
      end
      if (strobe.writeIndex) indexReg <= swapBytes(reqWdata);
      if (strobe.loadRsp) begin
        case (strobe.rdSel)
          RD_CFG:   rspRdata <= swapHeld ? swapBytes(cfgRspData) : cfgRspData;
          RD_IACK:  rspRdata <= {24'h0, iackVector};
          RD_INDEX: rspRdata <= swapBytes(indexReg);
          RD_ONES:  rspRdata <= '1;
          default:  rspRdata <= '0;
        endcase
      end
    end
  end

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    logic anyHit;
    always_comb begin
      anyHit = 1'b0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        for (int p = 0; p < PINS_PER_SLOT; p++) begin
          if (((p + s) % 2) == k) anyHit = anyHit | intPins[s*PINS_PER_SLOT + p];
        end
      end
    end
    assign irqOut[k] = anyHit;
  end

endmodule

// File: rtl/cfgdec_ctrl.sv
module cfgdec_ctrl
  import cfgdec_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  decode_t decode,
  input  logic    cfgRspValid,
  input  logic    iackValid,
  output logic    reqReady,
  output logic    claim,
  output strobe_t strobe,
  output logic    cfgReqValid,
  output logic    cfgReqWrite,
  output logic    iackReq,
  output logic    rspValid,
  output logic    rspError
);

  typedef enum logic [1:0] {ST_IDLE, ST_CFG, ST_IACK} state_e;

  state_e state, nextState;
  logic   accept, goCfg, goIack, respond, respondErr;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady && (decode.region != RG_MISS);
  assign claim    = accept;

  always_comb begin
    strobe     = '0;
    goCfg      = 1'b0;
    goIack     = 1'b0;
    respond    = 1'b0;
    respondErr = 1'b0;
    nextState  = state;
    case (state)
      ST_IDLE: if (accept) begin
        if (!decode.sizeOk) begin
          respond = 1'b1; respondErr = 1'b1; strobe.loadRsp = 1'b1;
        end else begin
          case (decode.region)
            RG_DIRECT: goCfg = 1'b1;
            RG_DATA: begin
              if (decode.legacyOn) goCfg = 1'b1;
              else begin
                respond = 1'b1; strobe.loadRsp = 1'b1;
                strobe.rdSel = reqWrite ? RD_ZERO : RD_ONES;
              end
            end
            RG_INDEX: begin
              respond = 1'b1; strobe.loadRsp = 1'b1;
              strobe.writeIndex = reqWrite;
              strobe.rdSel = reqWrite ? RD_ZERO : RD_INDEX;
            end
            RG_IACK: begin
              if (reqWrite) begin respond = 1'b1; strobe.loadRsp = 1'b1; end
              else goIack = 1'b1;
            end
            default: ;
          endcase
        end
      end
      ST_CFG: if (cfgRspValid) begin
        respond = 1'b1; strobe.loadRsp = 1'b1;
        strobe.rdSel = cfgReqWrite ? RD_ZERO : RD_CFG;
        nextState = ST_IDLE;
      end
      ST_IACK: if (iackValid) begin
        respond = 1'b1; strobe.loadRsp = 1'b1; strobe.rdSel = RD_IACK;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
    strobe.issueCfg = goCfg;
    if (goCfg)  nextState = ST_CFG;
    if (goIack) nextState = ST_IACK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      cfgReqValid <= 1'b0;
      cfgReqWrite <= 1'b0;
      iackReq     <= 1'b0;
      rspValid    <= 1'b0;
      rspError    <= 1'b0;
    end else begin
      state       <= nextState;
      cfgReqValid <= goCfg;
      iackReq     <= goIack;
      rspValid    <= respond;
      rspError    <= respondErr;
      if (goCfg) cfgReqWrite <= reqWrite;
    end
  end

endmodule

// File: rtl/cfg_cycle_decoder.sv
module cfg_cycle_decoder
  import cfgdec_pkg::*;
#(
  parameter logic [31:0] CFG_BASE      = 32'h8080_0000,
  parameter int          WIN_LOG2      = 22,
  parameter int          SEL_LSB       = 11,
  parameter int          SEL_BITS      = 11,
  parameter logic [31:0] IDX_ADDR      = 32'h0000_0CF8,
  parameter logic [31:0] DATA_ADDR     = 32'h0000_0CFC,
  parameter logic [31:0] IACK_ADDR     = 32'hBFFF_FFF0,
  parameter int          CFG_ADDR_W    = 24,
  parameter int          NUM_SLOTS     = 4,
  parameter int          PINS_PER_SLOT = 4,
  parameter int          NUM_IRQ       = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               reqValid,
  input  logic                               reqIo,
  input  logic                               reqWrite,
  input  logic [31:0]                        reqAddr,
  input  logic [1:0]                         reqSize,
  input  logic [31:0]                        reqWdata,
  output logic                               reqReady,
  output logic                               claim,
  output logic                               rspValid,
  output logic                               rspError,
  output logic [31:0]                        rspRdata,
  output logic                               cfgReqValid,
  output logic                               cfgReqWrite,
  output logic [CFG_ADDR_W-1:0]              cfgReqAddr,
  output logic [3:0]                         cfgReqBe,
  output logic [31:0]                        cfgReqWdata,
  input  logic                               cfgRspValid,
  input  logic [31:0]                        cfgRspData,
  output logic                               iackReq,
  input  logic                               iackValid,
  input  logic [7:0]                         iackVector,
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] intPins,
  output logic [NUM_IRQ-1:0]                 irqOut
);

  decode_t decode;
  strobe_t strobe;

  cfgdec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .decode(decode), .cfgRspValid(cfgRspValid), .iackValid(iackValid),
    .reqReady(reqReady), .claim(claim), .strobe(strobe),
    .cfgReqValid(cfgReqValid), .cfgReqWrite(cfgReqWrite), .iackReq(iackReq),
    .rspValid(rspValid), .rspError(rspError)
  );

  cfgdec_datapath #(
    .CFG_BASE(CFG_BASE), .WIN_LOG2(WIN_LOG2), .SEL_LSB(SEL_LSB),
    .SEL_BITS(SEL_BITS), .IDX_ADDR(IDX_ADDR), .DATA_ADDR(DATA_ADDR),
    .IACK_ADDR(IACK_ADDR), .CFG_ADDR_W(CFG_ADDR_W), .NUM_SLOTS(NUM_SLOTS),
    .PINS_PER_SLOT(PINS_PER_SLOT), .NUM_IRQ(NUM_IRQ)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqIo(reqIo), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .decode(decode), .strobe(strobe), .cfgRspData(cfgRspData),
    .iackVector(iackVector), .cfgReqAddr(cfgReqAddr), .cfgReqBe(cfgReqBe),
    .cfgReqWdata(cfgReqWdata), .rspRdata(rspRdata), .intPins(intPins),
    .irqOut(irqOut)
  );

endmodule

// File: rtl/cfgdec_checker.sv
module cfgdec_checker (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqIo,
  input logic       reqWrite,
  input logic [1:0] reqSize,
  input logic       reqReady,
  input logic       claim,
  input logic       rspValid,
  input logic       rspError,
  input logic       cfgReqValid,
  input logic [3:0] cfgReqBe,
  input logic       iackReq
);

  // R9: downstream request is a single-cycle pulse
  a_r9_cfg_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cfgReqValid |=> !cfgReqValid);

  // R9: no new request accepted while one is outstanding
  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    cfgReqValid |-> !reqReady);

  // R10: claim only for a presented request while idle
  a_r10_claim_gated: assert property (@(posedge clk) disable iff (!rstN)
    claim |-> (reqValid && reqReady));

  // R1: every downstream request follows a claimed access
  a_r1_issue_after_claim: assert property (@(posedge clk) disable iff (!rstN)
    cfgReqValid |-> $past(claim));

  // R8: acknowledge only for a claimed single-byte memory read
  a_r8_iack_byte_read: assert property (@(posedge clk) disable iff (!rstN)
    iackReq |-> ($past(claim) && !$past(reqWrite) && !$past(reqIo)
                 && $past(reqSize) == 2'd0));

  // R8: acknowledge and configuration requests never overlap
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgReqValid && iackReq));

  // R4: an error is only reported with a response
  a_r4_error_in_rsp: assert property (@(posedge clk) disable iff (!rstN)
    rspError |-> rspValid);

  // R4: a downstream request always enables at least one byte
  a_r4_be_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    cfgReqValid |-> (cfgReqBe != 4'h0));

endmodule

bind cfg_cycle_decoder cfgdec_checker u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIo(reqIo),
  .reqWrite(reqWrite), .reqSize(reqSize), .reqReady(reqReady),
  .claim(claim), .rspValid(rspValid), .rspError(rspError),
  .cfgReqValid(cfgReqValid), .cfgReqBe(cfgReqBe), .iackReq(iackReq)
);

// File: tb/tb_cfg_cycle_decoder.sv
`timescale 1ns/1ps
module tb_cfg_cycle_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqIo = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic [1:0]  reqSize = '0;
  logic        reqReady, claim, rspValid, rspError;
  logic [31:0] rspRdata;
  logic        cfgReqValid, cfgReqWrite;
  logic [23:0] cfgReqAddr;
  logic [3:0]  cfgReqBe;
  logic [31:0] cfgReqWdata;
  logic        cfgRspValid = 1'b0;
  logic [31:0] cfgRspData = '0;
  logic        iackReq;
  logic        iackValid = 1'b0;
  logic [7:0]  iackVector = '0;
  logic [15:0] intPins = '0;
  logic [3:0]  irqOut;

  int nChecks = 0, nErrors = 0;

  always #2.5 clk = ~clk;

  cfg_cycle_decoder dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIo(reqIo),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWdata(reqWdata), .reqReady(reqReady), .claim(claim),
    .rspValid(rspValid), .rspError(rspError), .rspRdata(rspRdata),
    .cfgReqValid(cfgReqValid), .cfgReqWrite(cfgReqWrite),
    .cfgReqAddr(cfgReqAddr), .cfgReqBe(cfgReqBe), .cfgReqWdata(cfgReqWdata),
    .cfgRspValid(cfgRspValid), .cfgRspData(cfgRspData), .iackReq(iackReq),
    .iackValid(iackValid), .iackVector(iackVector), .intPins(intPins),
    .irqOut(irqOut)
  );

  // observations of the last access
  logic        oClaim, oRsp, oErr, oCfg, oCfgWr, oIack, oBusyBad;
  logic [31:0] oData, oCfgWd;
  logic [23:0] oCfgAddr;
  logic [3:0]  oCfgBe;
  int          oCfgCycles;

  function automatic logic [31:0] swp(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic io, input logic wr, input logic [31:0] addr,
                        input logic [1:0] size, input logic [31:0] wd);
    int pendCfg, pendIack;
    pendCfg = 0; pendIack = 0;
    oClaim = 0; oRsp = 0; oErr = 0; oCfg = 0; oCfgWr = 0; oIack = 0;
    oBusyBad = 0; oData = '0; oCfgWd = '0; oCfgAddr = '0; oCfgBe = '0;
    oCfgCycles = 0;
    @(negedge clk);
    reqValid = 1'b1; reqIo = io; reqWrite = wr; reqAddr = addr;
    reqSize = size; reqWdata = wd;
    #1 oClaim = claim;
    @(negedge clk);
    reqValid = 1'b0;
    for (int c = 0; c < 30 && !oRsp; c++) begin
      if (cfgReqValid) begin
        oCfg = 1; oCfgCycles++; oCfgAddr = cfgReqAddr; oCfgBe = cfgReqBe;
        oCfgWd = cfgReqWdata; oCfgWr = cfgReqWrite; pendCfg = 3;
      end
      if (iackReq) begin oIack = 1; pendIack = 3; end
      if (rspValid) begin oRsp = 1; oErr = rspError; oData = rspRdata; end
      if ((pendCfg > 0 || pendIack > 0) && reqReady) oBusyBad = 1;
      cfgRspValid = (pendCfg == 1);
      iackValid   = (pendIack == 1);
      if (pendCfg > 0) pendCfg--;
      if (pendIack > 0) pendIack--;
      if (!oRsp) @(negedge clk);
    end
    cfgRspValid = 1'b0;
    iackValid   = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [31:0] a;
    logic [3:0]  expBe;
    logic        ok;
    logic [3:0]  expIrq;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R12: reset state
    chk("R12 reqReady", {31'b0, reqReady}, 32'd1);
    chk("R12 idle outs", {29'b0, rspValid, cfgReqValid, iackReq}, 32'd0);
    access(1, 0, 32'h0000_0CF8, 2'd2, '0);
    chk("R12 index zero", oData, 32'h0);

    // R3/R2/R5/R1/R9: select sweep, with extra higher bits set
    for (int i = 0; i <= 11; i++) begin
      a = 32'h8080_05A4;
      if (i < 11) a[11+i] = 1'b1;
      if (i < 10) a[21] = 1'b1;
      if (i < 9)  a[11+i+1] = 1'b1;
      cfgRspData = 32'hA1B2_C3D4 ^ i;
      access(0, 0, a, 2'd2, '0);
      chk("R1 claim", {31'b0, oClaim}, 32'd1);
      chk("R3 device", {8'b0, oCfgAddr}, {8'b0, 8'h00, 5'(i), 11'h5A4});
      chk("R4 be full", {28'b0, oCfgBe}, 32'hF);
      chk("R5 rdata", oData, 32'hA1B2_C3D4 ^ i);
      chk("R9 pulse", oCfgCycles, 1);
      chk("R9 busy", {31'b0, oBusyBad}, 32'd0);
    end

    // R1/R10: window edges and wrong space
    access(0, 0, 32'h807F_FFFC, 2'd2, '0);
    chk("R10 below", {29'b0, oClaim, oRsp, oCfg}, 32'd0);
    access(0, 0, 32'h80C0_0000, 2'd2, '0);
    chk("R10 above", {29'b0, oClaim, oRsp, oCfg}, 32'd0);
    access(1, 0, 32'h8080_0000, 2'd2, '0);
    chk("R1 io space miss", {29'b0, oClaim, oRsp, oCfg}, 32'd0);
    access(0, 0, 32'h80BF_FFFC, 2'd2, '0);
    chk("R2 top of window", {8'b0, oCfgAddr}, {8'b0, 8'h00, 5'd0, 11'h7FC});

    // R4/R5: size and alignment sweep on writes
    for (int s = 0; s < 4; s++) begin
      for (int l = 0; l < 4; l++) begin
        ok = (s == 0) || (s == 1 && l[0] == 0) || (s == 2 && l == 0);
        expBe = (s == 0) ? (4'b0001 << l) : (s == 1) ? (4'b0011 << l) : 4'b1111;
        access(0, 1, 32'h8080_1000 + l, 2'(s), 32'h1357_9BDF);
        chk("R4 error", {31'b0, oErr}, {31'b0, !ok});
        chk("R4 issued", {31'b0, oCfg}, {31'b0, ok});
        if (ok) begin
          chk("R4 be", {28'b0, oCfgBe}, {28'b0, expBe});
          chk("R5 wdata", oCfgWd, 32'h1357_9BDF);
          chk("R2 addr", {8'b0, oCfgAddr}, {8'b0, 8'h00, 5'd1, 9'b0, 2'(l)});
          chk("R9 write flag", {31'b0, oCfgWr}, 32'd1);
        end else begin
          chk("R4 err data", oData, 32'h0);
        end
      end
    end

    // R6: index register, big-endian
    access(1, 1, 32'h0000_0CF8, 2'd2, swp(32'h8005_1A40));
    chk("R6 write ok", {30'b0, oRsp, oErr}, 32'd2);
    access(1, 0, 32'h0000_0CF8, 2'd2, '0);
    chk("R6 readback", oData, swp(32'h8005_1A40));
    access(1, 1, 32'h0000_0CF8, 2'd0, 32'hFFFF_FFFF);
    chk("R6 byte write err", {30'b0, oRsp, oErr}, 32'd3);
    access(1, 0, 32'h0000_0CF8, 2'd2, '0);
    chk("R6 unchanged", oData, swp(32'h8005_1A40));

    // R7: data port enabled
    cfgRspData = 32'h1122_3344;
    access(1, 0, 32'h0000_0CFC, 2'd2, '0);
    chk("R7 addr", {8'b0, oCfgAddr}, 32'h0005_1A40);
    chk("R7 read swap", oData, 32'h4433_2211);
    access(1, 1, 32'h0000_0CFE, 2'd0, 32'h0000_AB00);
    chk("R7 wr addr", {8'b0, oCfgAddr}, 32'h0005_1A42);
    chk("R7 wr be", {28'b0, oCfgBe}, 32'h4);
    chk("R7 wr swap", oCfgWd, 32'h00AB_0000);

    // R7: data port disabled
    access(1, 1, 32'h0000_0CF8, 2'd2, swp(32'h0005_1A40));
    access(1, 0, 32'h0000_0CFC, 2'd2, '0);
    chk("R7 off read", oData, 32'hFFFF_FFFF);
    chk("R7 off no cfg", {30'b0, oCfg, oErr}, 32'd0);
    access(1, 1, 32'h0000_0CFC, 2'd2, 32'h5555_5555);
    chk("R7 off write", {29'b0, oRsp, oCfg, oErr}, 32'd4);

    // R8: interrupt acknowledge
    iackVector = 8'h5C;
    access(0, 0, 32'hBFFF_FFF0, 2'd0, '0);
    chk("R8 iack req", {31'b0, oIack}, 32'd1);
    chk("R8 vector", oData, 32'h0000_005C);
    chk("R8 no busy violation", {31'b0, oBusyBad}, 32'd0);
    access(0, 0, 32'hBFFF_FFF0, 2'd1, '0);
    chk("R8 wide err", {29'b0, oRsp, oErr, oIack}, 32'd6);
    access(0, 1, 32'hBFFF_FFF0, 2'd2, 32'hDEAD_BEEF);
    chk("R8 write ignored", {28'b0, oRsp, oErr, oIack, oCfg}, 32'd8);
    access(0, 0, 32'hBFFF_FFF4, 2'd0, '0);
    chk("R10 near iack miss", {29'b0, oClaim, oRsp, oIack}, 32'd0);

    // R11: exhaustive swizzle
    for (int v = 0; v < 65536; v++) begin
      intPins = 16'(v);
      expIrq = '0;
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 4; p++)
          expIrq[(p + s) % 2] = expIrq[(p + s) % 2] | intPins[s*4 + p];
      #0.05;
      chk("R11 swizzle", {28'b0, irqOut}, {28'b0, expIrq});
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule